// File: doc/BRIEF.md
# Reset Release Synchronizer and Stretcher

The block takes a chip-wide active-low reset, whose release is not aligned to any clock, and turns it into a clean synchronous reset and run enable for one clock domain. Reset is applied to all outputs as soon as the global reset goes low, with no clock edge needed. Release happens only on a clock edge, and only after a programmable number of edges. The run enable is meant to drive the clock enable of state machines and counters that must all start on the same cycle.

A lock indication from the clock generator is brought into the domain through a two-flop synchronizer. Release waits for that lock. If lock drops later, the run enable falls within two edges, and the full count starts again once lock returns. A second, short reset output comes from the global reset alone and clears on the second edge after release. It serves logic that only needs a reset release aligned to the clock.

The stretch length `DELAY_STAGES` is chosen from the clock rate. Its legal range is 2 to 16 and the default is 4. A value outside that range is clamped to the nearer limit. Each clock domain uses its own instance. Below, D stands for the effective stage count, and edge n means the n-th rising edge of `clk_i` after `rst_ni` goes high.

Top module: `rrs_reset_release`

## Requirements
- R1: While `rst_ni` is low, `srst_o`=1, `run_en_o`=0 and `early_srst_o`=1. These values appear without any clock edge and hold while the clock runs.
- R2: After edge n, `run_en_o` is 1 exactly when `lock_i` was sampled high at every one of the edges n-D-1 through n-1, and all of those edges come after release. With lock steady high, `run_en_o` therefore rises after edge D+2.
- R3: Release waits for lock. If `lock_i` is first driven high after edge m, `run_en_o` stays 0 through edge m+D+1 and is 1 from edge m+D+2 on.
- R4: If `lock_i` is sampled low at any edge, `run_en_o` is 0 after the next edge.
- R5: Every return of lock restarts the full count. A high run of `lock_i` shorter than D+1 sampled edges never raises `run_en_o`.
- R6: `srst_o` is always the complement of `run_en_o`.
- R7: `early_srst_o` stays 1 through edge 1 after release and is 0 from edge 2 on, whatever the value of `lock_i`.
- R8: `run_en_o` is never 1 while `early_srst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Domain clock |
| rst_ni | input | 1 | Global reset, active low, asynchronous |
| lock_i | input | 1 | Clock generator lock, asynchronous to the domain clock |
| srst_o | output | 1 | Synchronous reset, active high |
| run_en_o | output | 1 | Run enable for critical logic, active high |
| early_srst_o | output | 1 | Short synchronous reset that depends only on `rst_ni` |

## Verification
The hardest case to reach is a lock dropout that happens after the domain is already running, especially a dropout only one cycle wide. Such a pulse sits between the synchronizer and the release chain, and it must still cancel the enable and restart the count. The bench first lets the block reach the running state. It then drops `lock_i` for widths of one to five cycles, and separately feeds lock high bursts that are shorter than the window. Every output is compared each cycle against a window test over the bench's own record of the lock values it drove. Reset release is also swept across several phases inside the clock period and combined with several lock arrival delays.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int unsigned DELAY_MIN        = 2;
  localparam int unsigned DELAY_MAX        = 16;
  localparam int unsigned LOCK_SYNC_STAGES = 2;
  localparam int unsigned EARLY_STAGES     = 2;
endpackage

// File: rtl/rrs_sync_cell.sv
module rrs_sync_cell #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rrs_delay_line.sv
module rrs_delay_line #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  output logic out_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] stage, stage_d;
  logic [CW-1:0]    run_cnt;

  // head stage loads a constant 1; every stage is cleared while unqualified
  assign stage_d = {stage[DEPTH-2:0], 1'b1} & {DEPTH{qual_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage <= '0;
    else         stage <= stage_d;
  end

  assign out_o = stage[DEPTH-1];

  // consecutive qualified edges, saturating; used only by the checks below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_cnt <= '0;
    else if (!qual_i)              run_cnt <= '0;
    else if (run_cnt != CW'(DEPTH)) run_cnt <= run_cnt + 1'b1;
  end

  AST_CHAIN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o == (run_cnt == CW'(DEPTH)));  // R2

  AST_QUAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual_i |=> !out_o);  // R5
endmodule

// File: rtl/rrs_reset_release.sv
module rrs_reset_release
  import rrs_pkg::*;
#(
  parameter int unsigned DELAY_STAGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic srst_o,
  output logic run_en_o,
  output logic early_srst_o
);
  localparam int unsigned DLY = (DELAY_STAGES < DELAY_MIN) ? DELAY_MIN :
                                (DELAY_STAGES > DELAY_MAX) ? DELAY_MAX : DELAY_STAGES;

  logic lock_s;
  logic chain_q;

  rrs_sync_cell #(.STAGES(LOCK_SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lock_i),
    .q_o    (lock_s)
  );

  rrs_delay_line #(.DEPTH(DLY)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qual_i (lock_s),
    .out_o  (chain_q)
  );

  rrs_sync_cell #(.STAGES(EARLY_STAGES), .RST_VAL(1'b1)) u_early (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b0),
    .q_o    (early_srst_o)
  );

  // gate with the synced lock so a dropout cancels run one edge before the chain clears
  assign run_en_o = chain_q & lock_s;
  assign srst_o   = ~run_en_o;

  AST_LOCK_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_o) |-> $past(lock_i, 2));  // R3

  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |-> ##2 !run_en_o);  // R4

  AST_EARLY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_en_o |-> !early_srst_o);  // R8

  AST_EARLY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !early_srst_o |=> !early_srst_o);  // R7
endmodule

// File: tb/sim_rrs_reset_release.sv
module sim_rrs_reset_release;
  localparam int D = 4;

  logic clk    = 1'b0;
  logic rst_ni = 1'b0;
  logic lock_i = 1'b0;
  logic srst_o, run_en_o, early_srst_o;

  int n    = 0;
  int vec  = 0;
  int bad  = 0;
  bit hist [0:255];

  always #4 clk = ~clk;

  rrs_reset_release #(.DELAY_STAGES(D)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .lock_i       (lock_i),
    .srst_o       (srst_o),
    .run_en_o     (run_en_o),
    .early_srst_o (early_srst_o)
  );

  task automatic chk(input string r, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s n=%0d actual=%b expected=%b", r, n, act, exp);
    end
  endtask

  // R2 window rule over the lock values the bench itself drove
  function automatic logic exp_en();
    if (n < D + 2) return 1'b0;
    for (int k = n - D - 1; k <= n - 1; k++)
      if (!hist[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cyc(input string r, input logic nxt_lock);
    logic e;
    @(posedge clk);
    n++;
    if (n < 256) hist[n] = lock_i;
    @(negedge clk);
    e = exp_en();
    chk(r, run_en_o, e);
    chk("R6", srst_o, ~e);
    chk("R7", early_srst_o, n < 2);
    chk("R8", run_en_o & early_srst_o, 1'b0);
    lock_i = nxt_lock;
  endtask

  task automatic do_reset(input logic lk, input int phase);
    @(negedge clk);
    rst_ni = 1'b0;
    lock_i = lk;
    #1;
    chk("R1", srst_o, 1'b1);
    chk("R1", run_en_o, 1'b0);
    chk("R1", early_srst_o, 1'b1);
    repeat (2) @(negedge clk);
    chk("R1", srst_o, 1'b1);
    chk("R1", run_en_o, 1'b0);
    chk("R1", early_srst_o, 1'b1);
    for (int k = 0; k < 256; k++) hist[k] = 1'b0;
    n = 0;
    #(phase);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired n=%0d", n);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);

    // R2 / R3: lock arrival delay and reset release phase sweep
    for (int m = 0; m <= 6; m++) begin
      for (int ph = 0; ph <= 3; ph++) begin
        do_reset(m == 0, ph);
        for (int c = 1; c <= m + D + 4; c++)
          cyc((m == 0) ? "R2" : "R3", (c >= m) ? 1'b1 : 1'b0);
      end
    end

    // R4 / R5: dropouts of several widths after the domain is running
    for (int w = 1; w <= 5; w++) begin
      do_reset(1'b1, w % 4);
      for (int c = 0; c < D + 4; c++) cyc("R2", 1'b1);
      lock_i = 1'b0;
      for (int c = 1; c <= w; c++) cyc("R4", (c == w) ? 1'b1 : 1'b0);
      for (int c = 0; c < D + 4; c++) cyc("R5", 1'b1);
    end

    // R5: high bursts shorter than the window never release
    for (int hi = 1; hi <= D; hi++) begin
      do_reset(1'b0, 2);
      for (int rep = 0; rep < 3; rep++) begin
        for (int c = 0; c < hi; c++) cyc("R5", 1'b1);
        cyc("R5", 1'b0);
      end
      for (int c = 0; c < D + 4; c++) cyc("R5", 1'b1);
    end

    // R1: reset asserted while running, then a lock-less release for R7
    do_reset(1'b0, 1);
    for (int c = 0; c < 6; c++) cyc("R3", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule